// File: doc/BRIEF.md
# Counter Access Permission Checker

This block rules on reads of the user-level counter addresses. Each request gives a CSR address, the current privilege level and the virtualization bit. One cycle later the block answers with one of three outcomes: the access is allowed, it raises an illegal-instruction exception, or it raises a virtual-illegal-instruction exception. The ruling uses three counter-enable registers: machine, supervisor and hypervisor. Each register has one bit per counter, and bit i belongs to the counter at address 0xC00+i. All three registers are written through a single select-coded write port.

The block also forms the read value of the supervisor overflow-vector register. It takes the raw per-counter overflow flags and hides every bit that the current mode is not allowed to see. Instruction decode, trap entry and the counters themselves sit outside the block.

Top module: `cnt_access_guard`

## Requirements
- R1: After a synchronous reset, all three enable registers are zero, and `rsp_valid`, the three outcome flags and `ovf_view` are all zero.
- R2: A write with `en_wr` high loads `en_wr_data` whole into the register chosen by `en_wr_sel`: 0 is machine, 1 is supervisor, 2 is hypervisor. Select 3 changes nothing. A request in the same cycle as a write is judged on the old contents.
- R3: Addresses 0xC00 to 0xC1F map to counter index address−0xC00. A request to any other address produces a response with all three outcome flags low.
- R4: Privilege 2'b11 (machine) always gets `rsp_allow` for an in-range address, whatever the enable registers hold or the virtualization bit is.
- R5: Below machine level, a clear machine enable bit gives `rsp_illegal`, even in a virtualized mode.
- R6: In VS or VU mode (`req_virt`=1, privilege 2'b01 or 2'b00), a set machine bit with a clear hypervisor bit gives `rsp_virt_illegal`.
- R7: In user mode (privilege 2'b00), the supervisor enable bit must also be set. When it is clear and the machine and hypervisor checks pass, HU mode gives `rsp_illegal` and VU mode gives `rsp_virt_illegal`.
- R8: The response comes out exactly one cycle after the request, with `rsp_valid` high. For an in-range address exactly one outcome flag is high, and no flag is ever high without `rsp_valid`.
- R9: The reserved privilege encoding 2'b10 gives `rsp_illegal` for an in-range address.
- R10: One cycle after the inputs, `ovf_view` in machine mode equals `ovf_raw` with bits 2:0 forced to zero.
- R11: In HS mode `ovf_view` bit x is `ovf_raw[x]` AND machine bit x. In VS mode it is additionally ANDed with hypervisor bit x. In user modes and under privilege 2'b10 it is all zero. Bits 2:0 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr | input | 1 | Enable-register write strobe |
| en_wr_sel | input | 2 | Target register: 0 machine, 1 supervisor, 2 hypervisor, 3 none |
| en_wr_data | input | NCTR | Value written |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | AW | CSR address of the access |
| req_prv | input | 2 | Privilege: 3 machine, 1 supervisor, 0 user, 2 reserved |
| req_virt | input | 1 | Virtualization mode bit |
| ovf_raw | input | NCTR | Raw per-counter overflow flags |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_allow | output | 1 | Access permitted |
| rsp_illegal | output | 1 | Illegal-instruction exception |
| rsp_virt_illegal | output | 1 | Virtual-illegal-instruction exception |
| ovf_view | output | NCTR | Mode-masked overflow vector |

## Verification
The bench drives layered enable patterns that pull the three gates apart. A design with the wrong precedence would mislabel a request that misses both the machine and hypervisor bits as virtual-illegal. It would also report a VU-mode supervisor miss as a plain illegal exception. The bench probes the edges of the address window (0xBFF, 0xC1F, 0xC20), where an off-by-one decode would judge an outside address. It issues a write and a request in the same cycle, where a bypassed register would grant early. A select-3 write would corrupt a register if the select decode were loose. The overflow vector is checked in every mode with dense flag patterns. A wrong mask would leak bits 2:0, hypervisor-hidden bits, or user-mode bits.

// File: rtl/cperm_pkg.sv
package cperm_pkg;

  typedef enum logic [1:0] {
    WR_MACH = 2'd0,
    WR_SUPV = 2'd1,
    WR_HYP  = 2'd2,
    WR_NONE = 2'd3
  } en_sel_e;

  typedef enum logic [1:0] {
    PRV_U   = 2'd0,
    PRV_S   = 2'd1,
    PRV_RSV = 2'd2,
    PRV_M   = 2'd3
  } prv_e;

  typedef enum logic [1:0] {
    VERD_OK   = 2'd0,
    VERD_ILL  = 2'd1,
    VERD_VILL = 2'd2,
    VERD_NONE = 2'd3
  } verdict_e;

endpackage

// File: rtl/cperm_en_regs.sv
module cperm_en_regs
  import cperm_pkg::*;
#(
  parameter int NCTR = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  en_sel_e         wr_sel,
  input  logic [NCTR-1:0] wr_data,
  output logic [NCTR-1:0] m_en,
  output logic [NCTR-1:0] s_en,
  output logic [NCTR-1:0] h_en
);

  localparam int NBANK = 3;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    localparam logic [1:0] MY_SEL = 2'(g);
    logic [NCTR-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (wr_en && (wr_sel == en_sel_e'(MY_SEL))) begin
        q <= wr_data;
      end
    end
  end

  assign m_en = g_bank[0].q;
  assign s_en = g_bank[1].q;
  assign h_en = g_bank[2].q;

endmodule

// File: rtl/cperm_decide.sv
module cperm_decide
  import cperm_pkg::*;
#(
  parameter int              NCTR = 32,
  parameter int              AW   = 12,
  parameter logic [AW-1:0]   BASE = 12'hC00
) (
  input  logic [AW-1:0]   addr,
  input  prv_e            prv,
  input  logic            virt,
  input  logic [NCTR-1:0] m_en,
  input  logic [NCTR-1:0] s_en,
  input  logic [NCTR-1:0] h_en,
  output verdict_e        verdict
);

  localparam int IW = (NCTR > 1) ? $clog2(NCTR) : 1;

  logic [AW-1:0] off;
  logic          hit;
  logic [IW-1:0] idx;
  logic          mb, sb, hb;

  assign off = addr - BASE;
  assign hit = (addr >= BASE) && (off < AW'(NCTR));
  assign idx = off[IW-1:0];
  assign mb  = m_en[idx];
  assign sb  = s_en[idx];
  assign hb  = h_en[idx];

  always_comb begin
    if (!hit) begin
      verdict = VERD_NONE;
    end else if (prv == PRV_M) begin
      verdict = VERD_OK;
    end else if (prv == PRV_RSV) begin
      verdict = VERD_ILL;
    end else if (!mb) begin
      verdict = VERD_ILL;
    end else if (virt && !hb) begin
      verdict = VERD_VILL;
    end else if ((prv == PRV_U) && !sb) begin
      verdict = virt ? VERD_VILL : VERD_ILL;
    end else begin
      verdict = VERD_OK;
    end
  end

endmodule

// File: rtl/cperm_ovf_mask.sv
module cperm_ovf_mask
  import cperm_pkg::*;
#(
  parameter int NCTR   = 32,
  parameter int LOW_RO = 3
) (
  input  prv_e            prv,
  input  logic            virt,
  input  logic [NCTR-1:0] flags,
  input  logic [NCTR-1:0] m_en,
  input  logic [NCTR-1:0] h_en,
  output logic [NCTR-1:0] view
);

  localparam logic [NCTR-1:0] KEEP = {{(NCTR-LOW_RO){1'b1}}, {LOW_RO{1'b0}}};

  logic [NCTR-1:0] vis;

  always_comb begin
    case (prv)
      PRV_M:   vis = '1;
      PRV_S:   vis = virt ? (m_en & h_en) : m_en;
      default: vis = '0;
    endcase
  end

  assign view = flags & vis & KEEP;

endmodule

// File: rtl/cnt_access_guard.sv
module cnt_access_guard
  import cperm_pkg::*;
#(
  parameter int            NCTR = 32,
  parameter int            AW   = 12,
  parameter logic [AW-1:0] BASE = 12'hC00
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_wr,
  input  logic [1:0]      en_wr_sel,
  input  logic [NCTR-1:0] en_wr_data,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_addr,
  input  logic [1:0]      req_prv,
  input  logic            req_virt,
  input  logic [NCTR-1:0] ovf_raw,
  output logic            rsp_valid,
  output logic            rsp_allow,
  output logic            rsp_illegal,
  output logic            rsp_virt_illegal,
  output logic [NCTR-1:0] ovf_view
);

  logic [NCTR-1:0] m_en, s_en, h_en;
  logic [NCTR-1:0] view_c;
  verdict_e        verdict;

  cperm_en_regs #(.NCTR(NCTR)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (en_wr),
    .wr_sel  (en_sel_e'(en_wr_sel)),
    .wr_data (en_wr_data),
    .m_en    (m_en),
    .s_en    (s_en),
    .h_en    (h_en)
  );

  cperm_decide #(.NCTR(NCTR), .AW(AW), .BASE(BASE)) u_decide (
    .addr    (req_addr),
    .prv     (prv_e'(req_prv)),
    .virt    (req_virt),
    .m_en    (m_en),
    .s_en    (s_en),
    .h_en    (h_en),
    .verdict (verdict)
  );

  cperm_ovf_mask #(.NCTR(NCTR)) u_ovf (
    .prv   (prv_e'(req_prv)),
    .virt  (req_virt),
    .flags (ovf_raw),
    .m_en  (m_en),
    .h_en  (h_en),
    .view  (view_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid        <= 1'b0;
      rsp_allow        <= 1'b0;
      rsp_illegal      <= 1'b0;
      rsp_virt_illegal <= 1'b0;
      ovf_view         <= '0;
    end else begin
      rsp_valid        <= req_valid;
      rsp_allow        <= req_valid && (verdict == VERD_OK);
      rsp_illegal      <= req_valid && (verdict == VERD_ILL);
      rsp_virt_illegal <= req_valid && (verdict == VERD_VILL);
      ovf_view         <= view_c;
    end
  end

endmodule

// File: rtl/cnt_access_guard_chk.sv
module cnt_access_guard_chk #(
  parameter int            NCTR = 32,
  parameter int            AW   = 12,
  parameter logic [AW-1:0] BASE = 12'hC00
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [AW-1:0]   req_addr,
  input logic [1:0]      req_prv,
  input logic [NCTR-1:0] ovf_raw,
  input logic            rsp_valid,
  input logic            rsp_allow,
  input logic            rsp_illegal,
  input logic            rsp_virt_illegal,
  input logic [NCTR-1:0] ovf_view
);

  localparam logic [NCTR-1:0] HI = {{(NCTR-3){1'b1}}, 3'b000};

  logic in_win;
  assign in_win = (req_addr >= BASE) && ({1'b0, req_addr} < ({1'b0, BASE} + (AW+1)'(NCTR)));

  // R8: at most one outcome, never without a response
  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_allow, rsp_illegal, rsp_virt_illegal}));

  a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_allow || rsp_illegal || rsp_virt_illegal));

  a_r8_latency: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  a_r8_one_hot_hit: assert property (@(posedge clk) disable iff (rst)
    (req_valid && in_win) |=> $onehot({rsp_allow, rsp_illegal, rsp_virt_illegal}));

  // R4: machine level always passes
  a_r4_mach_pass: assert property (@(posedge clk) disable iff (rst)
    (req_valid && in_win && req_prv == 2'b11) |=> rsp_allow);

  // R9: reserved privilege refused
  a_r9_rsv_refused: assert property (@(posedge clk) disable iff (rst)
    (req_valid && in_win && req_prv == 2'b10) |=> rsp_illegal);

  // R3: outside the window nothing is decided
  a_r3_outside: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !in_win) |=> !(rsp_allow || rsp_illegal || rsp_virt_illegal));

  // R11: low bits of the overflow view stay zero
  a_r11_low_zero: assert property (@(posedge clk) disable iff (rst)
    ovf_view[2:0] == 3'b000);

  // R10: machine level sees all upper flags
  a_r10_mach_view: assert property (@(posedge clk) disable iff (rst)
    (req_prv == 2'b11) |=> (ovf_view == ($past(ovf_raw) & HI)));

  // R11: user level sees nothing
  a_r11_user_blind: assert property (@(posedge clk) disable iff (rst)
    (req_prv == 2'b00) |=> (ovf_view == '0));

endmodule

bind cnt_access_guard cnt_access_guard_chk #(.NCTR(NCTR), .AW(AW), .BASE(BASE)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .req_valid        (req_valid),
  .req_addr         (req_addr),
  .req_prv          (req_prv),
  .ovf_raw          (ovf_raw),
  .rsp_valid        (rsp_valid),
  .rsp_allow        (rsp_allow),
  .rsp_illegal      (rsp_illegal),
  .rsp_virt_illegal (rsp_virt_illegal),
  .ovf_view         (ovf_view)
);

// File: tb/sim_cnt_access_guard.sv
module sim_cnt_access_guard;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_wr = 1'b0;
  logic [1:0]  en_wr_sel = 2'd3;
  logic [31:0] en_wr_data = '0;
  logic        req_valid = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_prv = 2'd3;
  logic        req_virt = 1'b0;
  logic [31:0] ovf_raw = '0;
  logic        rsp_valid, rsp_allow, rsp_illegal, rsp_virt_illegal;
  logic [31:0] ovf_view;

  always #10 clk = ~clk;

  cnt_access_guard u0 (
    .clk (clk), .rst (rst), .en_wr (en_wr), .en_wr_sel (en_wr_sel),
    .en_wr_data (en_wr_data), .req_valid (req_valid), .req_addr (req_addr),
    .req_prv (req_prv), .req_virt (req_virt), .ovf_raw (ovf_raw),
    .rsp_valid (rsp_valid), .rsp_allow (rsp_allow), .rsp_illegal (rsp_illegal),
    .rsp_virt_illegal (rsp_virt_illegal), .ovf_view (ovf_view)
  );

  typedef struct {
    logic [2:0]  verd;
    logic [31:0] ovf;
    string       vtag;
    string       otag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          fails  = 0;
  logic [31:0] mm = '0, ss = '0, hh = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // {allow, illegal, virt_illegal}
  function automatic logic [2:0] exp_verd(input logic [11:0] a, input logic [1:0] p, input logic v);
    int i;
    if (a < 12'hC00 || a > 12'hC1F) return 3'b000;
    if (p == 2'b11) return 3'b100;
    if (p == 2'b10) return 3'b010;
    i = int'(a - 12'hC00);
    if (!mm[i]) return 3'b010;
    if (v && !hh[i]) return 3'b001;
    if (p == 2'b00 && !ss[i]) return v ? 3'b001 : 3'b010;
    return 3'b100;
  endfunction

  function automatic logic [31:0] exp_ovf(input logic [1:0] p, input logic v, input logic [31:0] f);
    logic [31:0] r;
    if (p == 2'b11)      r = f;
    else if (p == 2'b01) r = v ? (f & mm & hh) : (f & mm);
    else                 r = '0;
    return r & 32'hFFFF_FFF8;
  endfunction

  function automatic void model_wr(input logic [1:0] s, input logic [31:0] d);
    if (s == 2'd0) mm = d;
    else if (s == 2'd1) ss = d;
    else if (s == 2'd2) hh = d;
  endfunction

  task automatic req(input logic [11:0] a, input logic [1:0] p, input logic v,
                     input logic [31:0] f, input string vtag);
    exp_t e;
    @(negedge clk);
    en_wr = 1'b0; req_valid = 1'b1; req_addr = a; req_prv = p; req_virt = v; ovf_raw = f;
    e.verd = exp_verd(a, p, v);
    e.ovf  = exp_ovf(p, v, f);
    e.vtag = vtag;
    e.otag = (p == 2'b11) ? "R10" : "R11";
    sb.push_back(e);
  endtask

  task automatic req_wr(input logic [11:0] a, input logic [1:0] p, input logic v,
                        input logic [31:0] f, input logic [1:0] s, input logic [31:0] d,
                        input string vtag);
    exp_t e;
    @(negedge clk);
    en_wr = 1'b1; en_wr_sel = s; en_wr_data = d;
    req_valid = 1'b1; req_addr = a; req_prv = p; req_virt = v; ovf_raw = f;
    e.verd = exp_verd(a, p, v);
    e.ovf  = exp_ovf(p, v, f);
    e.vtag = vtag;
    e.otag = (p == 2'b11) ? "R10" : "R11";
    sb.push_back(e);
    model_wr(s, d);
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b0; en_wr = 1'b1; en_wr_sel = s; en_wr_data = d;
    model_wr(s, d);
  endtask

  task automatic quiet();
    @(negedge clk);
    req_valid = 1'b0; en_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // monitor: pops the scoreboard as responses appear
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && rsp_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R8", "unexpected response", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk({rsp_allow, rsp_illegal, rsp_virt_illegal} == e.verd, e.vtag, "outcome",
              {29'd0, rsp_allow, rsp_illegal, rsp_virt_illegal}, {29'd0, e.verd});
          chk(ovf_view == e.ovf, e.otag, "ovf_view", ovf_view, e.ovf);
        end
      end
    end
  end

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({rsp_valid, rsp_allow, rsp_illegal, rsp_virt_illegal} == 4'b0, "R1", "reset flags",
        {28'd0, rsp_valid, rsp_allow, rsp_illegal, rsp_virt_illegal}, 32'd0);
    chk(ovf_view == '0, "R1", "reset ovf_view", ovf_view, 32'd0);
    rst = 1'b0;

    // R1: enables start cleared
    req(12'hC00, 2'b01, 1'b0, 32'hFFFF_FFFF, "R1");
    req(12'hC05, 2'b00, 1'b1, 32'hFFFF_FFFF, "R1");
    // R4: machine always passes
    req(12'hC00, 2'b11, 1'b0, 32'hFFFF_FFFF, "R4");
    req(12'hC1F, 2'b11, 1'b1, 32'hA5A5_A5AF, "R4");
    // R3: window edges
    req(12'hC20, 2'b11, 1'b0, 32'h0000_00FF, "R3");
    req(12'hBFF, 2'b01, 1'b0, 32'h0000_00FF, "R3");
    req(12'hB00, 2'b11, 1'b0, 32'h0000_00FF, "R3");

    // R5: machine gate
    wr(2'd0, 32'h0000_00F5);
    req(12'hC00, 2'b01, 1'b0, 32'hFFFF_FFFF, "R5");
    req(12'hC01, 2'b01, 1'b0, 32'hFFFF_FFFF, "R5");
    req(12'hC02, 2'b01, 1'b0, 32'h5A5A_5A5F, "R5");
    // R6: hypervisor gate
    req(12'hC00, 2'b01, 1'b1, 32'hFFFF_FFFF, "R6");
    wr(2'd2, 32'h0000_0015);
    req(12'hC00, 2'b01, 1'b1, 32'hFFFF_FFFF, "R6");
    req(12'hC02, 2'b01, 1'b1, 32'hFFFF_FFFF, "R6");
    req(12'hC05, 2'b01, 1'b1, 32'hFFFF_FFFF, "R6");
    req(12'hC01, 2'b01, 1'b1, 32'hFFFF_FFFF, "R5");
    // R7: supervisor gate
    req(12'hC00, 2'b00, 1'b0, 32'hFFFF_FFFF, "R7");
    req(12'hC00, 2'b00, 1'b1, 32'hFFFF_FFFF, "R7");
    wr(2'd1, 32'h0000_0001);
    req(12'hC00, 2'b00, 1'b0, 32'hFFFF_FFFF, "R7");
    req(12'hC00, 2'b00, 1'b1, 32'hFFFF_FFFF, "R7");
    req(12'hC02, 2'b00, 1'b1, 32'hFFFF_FFFF, "R7");
    req(12'hC02, 2'b00, 1'b0, 32'hFFFF_FFFF, "R7");
    // R9: reserved privilege
    req(12'hC00, 2'b10, 1'b0, 32'hFFFF_FFFF, "R9");
    // R2: select 3 is inert, same-cycle write uses old value
    wr(2'd3, 32'hFFFF_FFFF);
    req(12'hC01, 2'b00, 1'b0, 32'hFFFF_FFFF, "R2");
    req(12'hC01, 2'b01, 1'b1, 32'hFFFF_FFFF, "R2");
    req_wr(12'hC1F, 2'b01, 1'b0, 32'hFFFF_FFFF, 2'd0, 32'hFFFF_FFFF, "R2");
    req(12'hC1F, 2'b01, 1'b0, 32'hFFFF_FFFF, "R2");
    req(12'hC1F, 2'b01, 1'b1, 32'h8000_0000, "R6");
    wr(2'd2, 32'hF0F0_F0F0);
    // R10/R11: overflow view across modes
    req(12'hC10, 2'b01, 1'b1, 32'hFFFF_FFFF, "R6");
    req(12'hC10, 2'b01, 1'b0, 32'h1234_5677, "R8");
    req(12'hC10, 2'b11, 1'b0, 32'h1234_5677, "R8");
    req(12'hC04, 2'b00, 1'b1, 32'hFFFF_FFFF, "R7");
    req(12'hC1E, 2'b10, 1'b1, 32'hFFFF_FFFF, "R9");

    quiet();
    quiet();
    quiet();
    chk(sb.size() == 0, "R8", "pending responses", sb.size(), 32'd0);
    finish_run();
  end

endmodule